// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a 32-bit virtual address into a physical address by walking a two-level translation tree held in memory. The top ten address bits select a word in a directory, whose location is held in a writable base register. That word names a 4 KB-aligned page table. The middle ten bits then select a word in that table, and the word gives the frame number of the target page. The low twelve bits pass through unchanged as the byte offset within the page.

A client presents one address at a time over a valid/ready request channel. It receives either a physical address or a fault over a valid/ready response channel. The fault reports whether the directory level or the table level held the missing entry.

The walk issues two dependent reads on a single-outstanding memory read port. The address of the second read comes from the data of the first. If the directory entry is not present, the walk stops after the first read.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_req_o` is 0.
- R2: The first read of a walk goes to `base + va[31:22]*4`. Here `base` is the value the base register held in the cycle the request was accepted.
- R3: When the directory word has bit 0 set, the second read goes to `{dir[31:12], 12'h000} + va[21:12]*4`.
- R4: When both words have bit 0 set, the response carries `rsp_fault_o`=0 and `rsp_paddr_o = {pte[31:12], va[11:0]}`.
- R5: When the directory word has bit 0 clear, no second read is issued. The response carries `rsp_fault_o`=1, `rsp_level_o`=0 (directory) and `rsp_paddr_o`=0.
- R6: When the table word has bit 0 clear, the response carries `rsp_fault_o`=1, `rsp_level_o`=1 (table) and `rsp_paddr_o`=0.
- R7: `mem_req_o` stays high with a constant `mem_addr_o` until `mem_rvalid_i` returns the data. Any number of wait cycles is tolerated.
- R8: A response stays valid and unchanged until `rsp_ready_i` is high. `req_ready_o` stays low from the acceptance of a request until its response is handed off.
- R9: A write to the base register changes only walks whose requests are accepted after the write. A walk already in progress keeps its captured base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_we_i | input | 1 | Base register write enable |
| base_wdata_i | input | 32 | New directory base (byte address) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Client takes the response |
| rsp_paddr_o | output | 32 | Physical address, zero on a fault |
| rsp_fault_o | output | 1 | Entry not present |
| rsp_level_o | output | 1 | Faulting level: 0 directory, 1 table |
| mem_req_o | output | 1 | Read request, held until data returns |
| mem_addr_o | output | 32 | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |

## Verification
The bench places entries at the extreme indices 0 and 1023 and offsets 0x000 and 0xFFF. A design that swapped or truncated an index field would read the wrong word and return the wrong frame.

The bench gives faults at both levels and counts the reads. A walker that went on to a second read after a missing directory entry would show a read count of two. A walker that reported the wrong level would fail the level check.

Read latencies range from zero to several wait cycles, and the response is held off for several cycles. A walker that moved its address early, or that dropped or changed its response, would be caught. The base register is rewritten in the middle of a walk. A design that used the live register instead of the captured value would address the wrong directory.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_READ_DIR = 2'd1,
    ST_READ_PTE = 2'd2,
    ST_DONE     = 2'd3
  } walk_state_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_PTE = 1'b1
  } fault_lvl_e;
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_o <= '0;
    else if (we_i) base_o <= wdata_i;
  end
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned AW        = 32,
  parameter int unsigned ENT_LOG2  = 2
) (
  input  logic [AW-1:0] tbl_base_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  always_comb addr_o = tbl_base_i + (idx_i << ENT_LOG2);
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DIR_W = 10,
  parameter int unsigned PG_W  = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_vaddr_i,
  input  logic [AW-1:0] base_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [AW-1:0] rsp_paddr_o,
  output logic          rsp_fault_o,
  output logic          rsp_level_o,
  output logic          mem_req_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic [AW-1:0] tbl_base_o,
  output logic [AW-1:0] tbl_idx_o
);
  localparam int unsigned FRAME_W = AW - OFF_W;
  localparam int unsigned PG_LSB  = OFF_W;
  localparam int unsigned DIR_LSB = OFF_W + PG_W;

  walk_state_e          state_q;
  logic [AW-1:0]        va_q;
  logic [AW-1:0]        dir_base_q;
  logic [FRAME_W-1:0]   tbase_q;
  logic [AW-1:0]        paddr_q;
  logic                 fault_q;
  fault_lvl_e           lvl_q;
  logic                 entry_ok;

  assign entry_ok    = mem_rdata_i[0];
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_DONE);
  assign mem_req_o   = (state_q == ST_READ_DIR) || (state_q == ST_READ_PTE);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;
  assign rsp_level_o = lvl_q;

  always_comb begin
    if (state_q == ST_READ_PTE) begin
      tbl_base_o = {tbase_q, {OFF_W{1'b0}}};
      tbl_idx_o  = AW'(va_q[PG_LSB +: PG_W]);
    end else begin
      tbl_base_o = dir_base_q;
      tbl_idx_o  = AW'(va_q[DIR_LSB +: DIR_W]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      dir_base_q <= '0;
      tbase_q    <= '0;
      paddr_q    <= '0;
      fault_q    <= 1'b0;
      lvl_q      <= LVL_DIR;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q       <= req_vaddr_i;
          dir_base_q <= base_i;
          state_q    <= ST_READ_DIR;
        end
        ST_READ_DIR: if (mem_rvalid_i) begin
          if (entry_ok) begin
            tbase_q <= mem_rdata_i[AW-1:OFF_W];
            state_q <= ST_READ_PTE;
          end else begin
            paddr_q <= '0;
            fault_q <= 1'b1;
            lvl_q   <= LVL_DIR;
            state_q <= ST_DONE;
          end
        end
        ST_READ_PTE: if (mem_rvalid_i) begin
          fault_q <= !entry_ok;
          lvl_q   <= LVL_PTE;
          paddr_q <= entry_ok ? {mem_rdata_i[AW-1:OFF_W], va_q[OFF_W-1:0]} : '0;
          state_q <= ST_DONE;
        end
        ST_DONE: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(tbl_base_o) && $stable(tbl_idx_o)); // R7
  AST_RSP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)); // R8
  AST_DIR_MISS_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ_DIR) && mem_rvalid_i && !mem_rdata_i[0]
      |=> rsp_valid_o && rsp_fault_o && !rsp_level_o && !mem_req_o); // R5
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !rsp_valid_o); // R8
  AST_PTE_MISS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READ_PTE) && mem_rvalid_i && !mem_rdata_i[0]
      |=> rsp_fault_o && rsp_level_o && (rsp_paddr_o == '0)); // R6
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned AW       = 32,
  parameter int unsigned DIR_W    = 10,
  parameter int unsigned PG_W     = 10,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned ENT_LOG2 = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_wdata_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_vaddr_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [AW-1:0] rsp_paddr_o,
  output logic          rsp_fault_o,
  output logic          rsp_level_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] tbl_base;
  logic [AW-1:0] tbl_idx;

  pt_base_reg #(.AW(AW)) i_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .wdata_i (base_wdata_i),
    .base_o  (base_q)
  );

  pt_walk_fsm #(.AW(AW), .DIR_W(DIR_W), .PG_W(PG_W), .OFF_W(OFF_W)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_vaddr_i  (req_vaddr_i),
    .base_i       (base_q),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_ready_i  (rsp_ready_i),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_fault_o  (rsp_fault_o),
    .rsp_level_o  (rsp_level_o),
    .mem_req_o    (mem_req_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .tbl_base_o   (tbl_base),
    .tbl_idx_o    (tbl_idx)
  );

  pt_entry_addr #(.AW(AW), .ENT_LOG2(ENT_LOG2)) i_addr (
    .tbl_base_i (tbl_base),
    .idx_i      (tbl_idx),
    .addr_o     (mem_addr_o)
  );

  AST_REQ_ONLY_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o); // R8
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_level;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  pt_walker i_pt_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .base_we_i(base_we), .base_wdata_i(base_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_paddr_o(rsp_paddr),
    .rsp_fault_o(rsp_fault), .rsp_level_o(rsp_level),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mem_q [logic [31:0]];
  int          mem_delay = 0;
  int          wait_cnt = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [4];

  always @(posedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= mem_delay) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_q.exists(mem_addr) ? mem_q[mem_addr] : 32'h0;
        if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
        rd_cnt   <= rd_cnt + 1;
        wait_cnt <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // vectors: va, expected paddr, fault, level, table base, read delay
  localparam int NV = 6;
  localparam logic [31:0] V_VA  [NV] = '{32'h0040_5123, 32'h0040_0FFF, 32'h007F_F000,
                                         32'h0080_1000, 32'hFFFF_FABC, 32'h0000_0010};
  localparam logic [31:0] V_PA  [NV] = '{32'hABCD_E123, 32'h1234_5FFF, 32'h0,
                                         32'h0, 32'hFFFF_FABC, 32'h0};
  localparam bit          V_FLT [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam bit          V_LVL [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] V_TB  [NV] = '{32'h0020_0000, 32'h0020_0000, 32'h0020_0000,
                                         32'h0, 32'h0040_0000, 32'h0};
  localparam int          V_DLY [NV] = '{0, 1, 3, 2, 0, 4};

  logic [31:0] got_pa;
  logic        got_flt;
  logic        got_lvl;

  task automatic walk(input logic [31:0] va, input int dly, input int hold, input logic [31:0] new_base, input bit wr_mid);
    int n;
    mem_delay = dly;
    rd_cnt = 0;
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 busy after accept", {31'b0, req_ready}, 32'h0);
    if (wr_mid) begin
      base_we = 1'b1;
      base_wdata = new_base;
      @(negedge clk);
      base_we = 1'b0;
    end
    n = 0;
    while (!rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid, "R7 response arrives", {31'b0, rsp_valid}, 32'h1);
    got_pa = rsp_paddr;
    got_flt = rsp_fault;
    got_lvl = rsp_level;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == got_pa && rsp_fault == got_flt && !req_ready,
          "R8 response held", rsp_paddr, got_pa);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R8 handoff returns to idle", {31'b0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    mem_q[32'h0010_0004] = 32'h0020_0001;
    mem_q[32'h0010_0008] = 32'h0030_0000;
    mem_q[32'h0010_0FFC] = 32'h0040_0001;
    mem_q[32'h0020_0014] = 32'hABCD_E001;
    mem_q[32'h0020_0000] = 32'h1234_5001;
    mem_q[32'h0020_0FFC] = 32'h7777_7000;
    mem_q[32'h0040_0FFC] = 32'hFFFF_F001;
    mem_q[32'h0050_0004] = 32'h0060_0001;
    mem_q[32'h0060_0014] = 32'h0BEE_F001;

    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1 reset state", {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1 idle after reset", {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);

    base_we = 1'b1;
    base_wdata = 32'h0010_0000;
    @(negedge clk);
    base_we = 1'b0;

    for (int v = 0; v < NV; v++) begin
      walk(V_VA[v], V_DLY[v], v % 3, 32'h0, 1'b0);
      chk(rd_addr[0] == 32'h0010_0000 + {20'b0, V_VA[v][31:22], 2'b0}, "R2 directory read address",
          rd_addr[0], 32'h0010_0000 + {20'b0, V_VA[v][31:22], 2'b0});
      if (V_FLT[v] && !V_LVL[v]) begin
        chk(rd_cnt == 1, "R5 single read on directory miss", rd_cnt, 32'd1);
      end else begin
        chk(rd_cnt == 2, "R3 two reads", rd_cnt, 32'd2);
        chk(rd_addr[1] == V_TB[v] + {20'b0, V_VA[v][21:12], 2'b0}, "R3 table read address",
            rd_addr[1], V_TB[v] + {20'b0, V_VA[v][21:12], 2'b0});
      end
      chk(got_flt == V_FLT[v], V_FLT[v] ? (V_LVL[v] ? "R6 fault flag" : "R5 fault flag") : "R4 fault flag",
          {31'b0, got_flt}, {31'b0, V_FLT[v]});
      if (V_FLT[v])
        chk(got_lvl == V_LVL[v], V_LVL[v] ? "R6 fault level" : "R5 fault level", {31'b0, got_lvl}, {31'b0, V_LVL[v]});
      chk(got_pa == V_PA[v], V_FLT[v] ? "R5 R6 paddr zero on fault" : "R4 physical address", got_pa, V_PA[v]);
    end

    // R9: base rewritten mid-walk must not affect it
    walk(32'h0040_5123, 3, 0, 32'h0050_0000, 1'b1);
    chk(rd_addr[0] == 32'h0010_0004, "R9 captured base kept", rd_addr[0], 32'h0010_0004);
    chk(got_pa == 32'hABCD_E123, "R9 old mapping result", got_pa, 32'hABCD_E123);
    walk(32'h0040_5123, 1, 4, 32'h0, 1'b0);
    chk(rd_addr[0] == 32'h0050_0004, "R9 new base used", rd_addr[0], 32'h0050_0004);
    chk(got_pa == 32'h0BEE_F123, "R9 new mapping result", got_pa, 32'h0BEE_F123);

    // R7: long wait on memory, request held
    walk(32'hFFFF_F000, 12, 1, 32'h0, 1'b0);
    chk(got_pa == 32'h0 && got_flt && !got_lvl, "R7 long wait dir miss", got_pa, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule